// File: doc/BRIEF.md
# Lock Elision Tracking Buffer

This block keeps a small table of the locks that a thread currently skips taking during speculative execution. When the front end sees a write hinted as a lock acquire, it presents the lock address, the value the lock holds before the write, and the value the write would store. The block answers in the same cycle: either elide, in which case the write is held back and an entry records the lock, or fall back, in which case the write is performed as an ordinary store. A release-hinted write is matched against the table. If it restores the value recorded at acquire time, the entry is freed and the write is elided. If the address matches but the value does not, the block requests an abort. A release to an address with no entry is an ordinary store.

Loads probe the table so that the elided thread reads back the value its own acquire would have written, and sees itself as holding the lock. Commit is granted only when no lock is still held. After any abort, whether signalled from outside or raised by the block itself, all entries are dropped and elision stays off until the next commit, so the re-executed region takes every lock for real. A new-transaction pulse drops all entries without changing that mode. Hints are advisory: misusing them can only lose elision and never produces a wrong value.

Top module: `lock_elide_tracker`

## Requirements
- R1: After reset the table is empty: a load probe misses, and `commit_ok` follows `commit_ready`. Elision is enabled.
- R2: With `acq_valid` high, exactly one of `acq_elide` and `acq_fallback` is high in the same cycle. Both are low without `acq_valid`. An acquire is elided when elision is enabled, a slot is free, the address is not already held, and no abort or new-transaction pulse is present in that cycle.
- R3: A load probe with `ld_valid` to an address held in the table sets `ld_hit` and returns on `ld_data` the value the elided acquire would have written. A probe to any other address sets `ld_hit` low.
- R4: When all DEPTH slots are held, a further acquire to a new address gets `acq_fallback`, does not raise `abort_req`, and records no entry.
- R5: A release whose address matches an entry and whose value equals the lock value saved at acquire time sets `rel_elide` and frees that entry, so later loads to that address miss.
- R6: A release whose address matches an entry but whose value differs from the saved value sets `abort_req` and leaves `rel_elide` low. All entries are then dropped and elision is disabled.
- R7: A release to an address that has no entry leaves both `rel_elide` and `abort_req` low, so the write proceeds normally.
- R8: `abort_in` drops all entries and disables elision. From the next cycle, every acquire gets `acq_fallback` until a commit.
- R9: `commit_ok` is high only when `commit_ready` is high and no entry is held. A granted commit re-enables elision from the next cycle.
- R10: `txn_start` drops all entries but leaves the elision mode unchanged.
- R11: An acquire to an address already held gets `acq_fallback` and adds no second entry.
- R12: A slot freed by a release can be allocated again by a later acquire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_valid | input | 1 | Acquire-hinted write present |
| acq_addr | input | AW | Lock address of the acquire |
| acq_old | input | DW | Lock value before the acquire write |
| acq_wdata | input | DW | Value the acquire write would store |
| acq_elide | output | 1 | Acquire elided |
| acq_fallback | output | 1 | Acquire to be performed as a normal write |
| rel_valid | input | 1 | Release-hinted write present |
| rel_addr | input | AW | Lock address of the release |
| rel_wdata | input | DW | Value the release write stores |
| rel_elide | output | 1 | Release matched and elided |
| abort_req | output | 1 | Release broke the elision rule; abort requested |
| ld_valid | input | 1 | Load probe present |
| ld_addr | input | AW | Load probe address |
| ld_hit | output | 1 | Load hits an elided lock |
| ld_data | output | DW | Value seen by the load on a hit |
| abort_in | input | 1 | Transaction abort from outside |
| commit_ready | input | 1 | Transaction wants to commit |
| commit_ok | output | 1 | Commit granted |
| txn_start | input | 1 | New-transaction pulse |

## Verification
The bench builds the block with DEPTH=4, AW=16 and DW=8. A depth of four lets a handful of acquires fill the table, so the full-table fallback, slot reuse after a release, and commit refusal with locks still held are each reached in a few cycles. The narrow data width keeps value mismatches on release easy to construct. The abort paths, both the one from outside and the one the block raises itself, are followed into the fallback mode and back out through a commit.

// File: rtl/lock_elide_pkg.sv
// Shared types for the lock elision tracking buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package lock_elide_pkg;

    // Elision mode of the tracker: normal speculation or forced plain writes
    typedef enum logic {
        MODE_ELIDE = 1'b0,
        MODE_PLAIN = 1'b1
    } elide_mode_e;

endpackage

// File: rtl/lock_elide_pick.sv
// Lowest-free-slot picker.
// Produces a one-hot grant for the lowest-numbered slot whose valid bit is
// clear, and a flag saying whether any slot is free.
// Assumes: DEPTH >= 1.
module lock_elide_pick #(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] busy,
    output logic [DEPTH-1:0] grant,
    output logic             any_free
);

    logic [DEPTH:0] taken;

    assign taken[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_chain
            // a slot wins if it is free and no lower slot already won
            assign grant[gi]     = ~busy[gi] & ~taken[gi];
            assign taken[gi + 1] = taken[gi] | ~busy[gi];
        end
    endgenerate

    assign any_free = taken[DEPTH];

endmodule

// File: rtl/lock_elide_cam.sv
// Address match array.
// Compares one key against every slot address and reports a hit vector
// restricted to valid slots.
// Assumes: at most one valid slot holds any address (the tracker keeps this).
module lock_elide_cam #(
    parameter int DEPTH = 4,
    parameter int AW    = 32
) (
    input  logic [DEPTH-1:0]         live,
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    input  logic [AW-1:0]            key,
    output logic [DEPTH-1:0]         hit
);

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
            // per-slot compare gated by the valid bit
            assign hit[gi] = live[gi] && (slot_addr[gi] == key);
        end
    endgenerate

endmodule

// File: rtl/lock_elide_mode.sv
// Elision mode register.
// Switches to plain-write mode on any abort and back to elide mode on a
// granted commit; an abort in the same cycle as a commit wins.
// Assumes: synchronous active-low reset, reset state is elide mode.
module lock_elide_mode
    import lock_elide_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        kill,
    input  logic        commit,
    output elide_mode_e mode
);

    // hold the current mode, abort taking priority over commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_ELIDE;
        end else if (kill) begin
            mode <= MODE_PLAIN;
        end else if (commit) begin
            mode <= MODE_ELIDE;
        end
    end

endmodule

// File: rtl/lock_elide_tracker.sv
// Lock elision tracking buffer (top).
// Holds up to DEPTH elided locks. Each slot keeps the lock address, the lock
// value seen before the elided acquire, and the value the acquire would have
// written. Decisions for acquire, release and load probes are combinational
// in the cycle of the request; table updates take effect at the next edge.
// Assumes: at most one acquire, one release and one load per cycle; the
// caller performs the write itself whenever a fallback is signalled.
module lock_elide_tracker
    import lock_elide_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq_valid,
    input  logic [AW-1:0] acq_addr,
    input  logic [DW-1:0] acq_old,
    input  logic [DW-1:0] acq_wdata,
    output logic          acq_elide,
    output logic          acq_fallback,
    input  logic          rel_valid,
    input  logic [AW-1:0] rel_addr,
    input  logic [DW-1:0] rel_wdata,
    output logic          rel_elide,
    output logic          abort_req,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    input  logic          abort_in,
    input  logic          commit_ready,
    output logic          commit_ok,
    input  logic          txn_start
);

    localparam int SLOT_BITS = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]         slot_live;
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0][DW-1:0] slot_saved;
    logic [DEPTH-1:0][DW-1:0] slot_held;

    logic [DEPTH-1:0] acq_hit_v;
    logic [DEPTH-1:0] rel_hit_v;
    logic [DEPTH-1:0] ld_hit_v;
    logic [DEPTH-1:0] free_grant;
    logic             free_any;

    logic [DW-1:0]    rel_saved;
    logic             rel_match;
    logic             rel_good;
    logic             acq_take;
    logic             wipe;
    logic             kill;
    logic             table_empty;
    elide_mode_e      mode;

    // three probes share one compare structure each
    lock_elide_cam #(.DEPTH(DEPTH), .AW(AW)) u_cam_acq (
        .live(slot_live), .slot_addr(slot_addr), .key(acq_addr), .hit(acq_hit_v)
    );
    lock_elide_cam #(.DEPTH(DEPTH), .AW(AW)) u_cam_rel (
        .live(slot_live), .slot_addr(slot_addr), .key(rel_addr), .hit(rel_hit_v)
    );
    lock_elide_cam #(.DEPTH(DEPTH), .AW(AW)) u_cam_ld (
        .live(slot_live), .slot_addr(slot_addr), .key(ld_addr), .hit(ld_hit_v)
    );

    lock_elide_pick #(.DEPTH(DEPTH)) u_pick (
        .busy(slot_live), .grant(free_grant), .any_free(free_any)
    );

    lock_elide_mode u_mode (
        .clk(clk), .rst_n(rst_n), .kill(kill), .commit(commit_ok), .mode(mode)
    );

    // one-hot selection of the saved value for the release and the held value for the load
    always_comb begin
        rel_saved = '0;
        ld_data   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rel_hit_v[i]) rel_saved = rel_saved | slot_saved[i];
            if (ld_hit_v[i])  ld_data   = ld_data   | slot_held[i];
        end
    end

    // release rule: matching address must restore the saved lock value
    always_comb begin
        rel_match = rel_valid && (|rel_hit_v);
        rel_good  = rel_match && (rel_wdata == rel_saved);
        abort_req = rel_match && (rel_wdata != rel_saved);
        rel_elide = rel_good && !abort_in;
    end

    // abort sources and table wipe conditions
    always_comb begin
        kill = abort_in || abort_req;
        wipe = kill || txn_start;
    end

    // acquire decision: mode, free slot, no duplicate, no wipe this cycle
    always_comb begin
        acq_take     = acq_valid && (mode == MODE_ELIDE) && free_any
                       && !(|acq_hit_v) && !wipe;
        acq_elide    = acq_take;
        acq_fallback = acq_valid && !acq_take;
    end

    // load forwarding and commit gate
    always_comb begin
        table_empty = ~(|slot_live);
        ld_hit      = ld_valid && (|ld_hit_v);
        commit_ok   = commit_ready && table_empty;
    end

    // slot table update: wipe, free on good release, fill on elided acquire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_live  <= '0;
            slot_addr  <= '0;
            slot_saved <= '0;
            slot_held  <= '0;
        end else if (wipe) begin
            slot_live <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (rel_good && rel_hit_v[i]) begin
                    slot_live[i] <= 1'b0;
                end
                if (acq_take && free_grant[i]) begin
                    slot_live[i]  <= 1'b1;
                    slot_addr[i]  <= acq_addr;
                    slot_saved[i] <= acq_old;
                    slot_held[i]  <= acq_wdata;
                end
            end
        end
    end

    logic [SLOT_BITS-1:0] unused_width_probe;
    assign unused_width_probe = '0;

endmodule

// File: rtl/lock_elide_chk.sv
// Property checker for the lock elision tracking buffer, bound to the top.
// Observes only ports of the tracker.
module lock_elide_chk (
    input logic clk,
    input logic rst_n,
    input logic acq_valid,
    input logic acq_elide,
    input logic acq_fallback,
    input logic rel_valid,
    input logic rel_elide,
    input logic abort_req,
    input logic ld_hit,
    input logic abort_in,
    input logic commit_ready,
    input logic commit_ok,
    input logic txn_start
);

    // R2
    acq_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_valid |-> ($countones({acq_elide, acq_fallback}) == 1));

    // R2
    acq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_valid |-> (!acq_elide && !acq_fallback));

    // R6
    rel_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> (rel_valid && !rel_elide));

    // R6
    self_abort_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (!acq_elide && !ld_hit));

    // R8
    ext_abort_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_in |=> (!acq_elide && !ld_hit));

    // R9
    commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ok |-> (commit_ready && !ld_hit));

    // R10
    txn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> !ld_hit);

endmodule

bind lock_elide_tracker lock_elide_chk u_lock_elide_chk (
    .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_elide(acq_elide),
    .acq_fallback(acq_fallback), .rel_valid(rel_valid), .rel_elide(rel_elide),
    .abort_req(abort_req), .ld_hit(ld_hit), .abort_in(abort_in),
    .commit_ready(commit_ready), .commit_ok(commit_ok), .txn_start(txn_start)
);

// File: tb/test_lock_elide_tracker.sv
// Directed bench for the lock elision tracking buffer.
module test_lock_elide_tracker;

    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          acq_valid, rel_valid, ld_valid;
    logic [AW-1:0] acq_addr, rel_addr, ld_addr;
    logic [DW-1:0] acq_old, acq_wdata, rel_wdata;
    logic          acq_elide, acq_fallback, rel_elide, abort_req, ld_hit;
    logic [DW-1:0] ld_data;
    logic          abort_in, commit_ready, commit_ok, txn_start;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lock_elide_tracker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_lock_elide_tracker (
        .clk(clk), .rst_n(rst_n),
        .acq_valid(acq_valid), .acq_addr(acq_addr), .acq_old(acq_old),
        .acq_wdata(acq_wdata), .acq_elide(acq_elide), .acq_fallback(acq_fallback),
        .rel_valid(rel_valid), .rel_addr(rel_addr), .rel_wdata(rel_wdata),
        .rel_elide(rel_elide), .abort_req(abort_req),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .abort_in(abort_in), .commit_ready(commit_ready), .commit_ok(commit_ok),
        .txn_start(txn_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // clear all request inputs at a falling edge
    task automatic idle_inputs();
        acq_valid = 0; rel_valid = 0; ld_valid = 0;
        abort_in = 0; commit_ready = 0; txn_start = 0;
        acq_addr = 0; acq_old = 0; acq_wdata = 0;
        rel_addr = 0; rel_wdata = 0; ld_addr = 0;
    endtask

    // start a new cycle: falling edge, clear, caller then sets inputs
    task automatic begin_cycle();
        @(negedge clk);
        idle_inputs();
    endtask

    // let combinational outputs settle, caller checks, then consume the edge
    task automatic settle();
        #4;
    endtask

    task automatic acq(input logic [AW-1:0] a, input logic [DW-1:0] o,
                       input logic [DW-1:0] w, input bit exp_el, input string req);
        begin_cycle();
        acq_valid = 1; acq_addr = a; acq_old = o; acq_wdata = w;
        settle();
        chk(acq_elide == exp_el, req, acq_elide, exp_el);
        chk(acq_fallback == !exp_el, req, acq_fallback, !exp_el);
        chk(abort_req == 0, req, abort_req, 0);
        @(posedge clk);
    endtask

    task automatic rel(input logic [AW-1:0] a, input logic [DW-1:0] v,
                       input bit exp_el, input bit exp_ab, input string req);
        begin_cycle();
        rel_valid = 1; rel_addr = a; rel_wdata = v;
        settle();
        chk(rel_elide == exp_el, req, rel_elide, exp_el);
        chk(abort_req == exp_ab, req, abort_req, exp_ab);
        @(posedge clk);
    endtask

    task automatic ld(input logic [AW-1:0] a, input bit exp_hit,
                      input logic [DW-1:0] exp_d, input string req);
        begin_cycle();
        ld_valid = 1; ld_addr = a;
        settle();
        chk(ld_hit == exp_hit, req, ld_hit, exp_hit);
        if (exp_hit) chk(ld_data == exp_d, req, ld_data, exp_d);
        @(posedge clk);
    endtask

    task automatic commit(input bit exp_ok, input string req);
        begin_cycle();
        commit_ready = 1;
        settle();
        chk(commit_ok == exp_ok, req, commit_ok, exp_ok);
        @(posedge clk);
    endtask

    task automatic pulse_abort();
        begin_cycle(); abort_in = 1; @(posedge clk);
    endtask

    task automatic pulse_txn();
        begin_cycle(); txn_start = 1; @(posedge clk);
    endtask

    task automatic t_reset();
        begin_cycle();
        rst_n = 0;
        repeat (2) @(posedge clk);
        begin_cycle();
        rst_n = 1;
        @(posedge clk);
        ld(16'h1000, 0, 0, "R1 load misses after reset");
        begin_cycle();
        settle();
        chk(!acq_elide && !acq_fallback, "R2 no decision while idle", {acq_elide, acq_fallback}, 0);
        @(posedge clk);
        commit(1, "R1 commit granted on empty table");
    endtask

    task automatic t_basic();
        acq(16'h1000, 8'h00, 8'h01, 1, "R2 acquire elided");
        ld(16'h1000, 1, 8'h01, "R3 load sees held value");
        ld(16'h2000, 0, 0, "R3 other address misses");
        commit(0, "R9 commit refused with lock held");
        rel(16'h1000, 8'h00, 1, 0, "R5 matching release elided");
        ld(16'h1000, 0, 0, "R5 entry freed");
        commit(1, "R9 commit granted once empty");
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++)
            acq(16'h3000 + 16'(i), 8'(i), 8'h80 + 8'(i), 1, "R2 fill slot");
        acq(16'h3100, 8'h00, 8'h01, 0, "R4 full table falls back");
        ld(16'h3100, 0, 0, "R4 no entry for fallback lock");
        ld(16'h3003, 1, 8'h83, "R3 last slot held value");
        rel(16'h3002, 8'h02, 1, 0, "R5 release slot two");
        acq(16'h3100, 8'h00, 8'h44, 1, "R12 freed slot reused");
        ld(16'h3100, 1, 8'h44, "R12 reused slot forwards");
        rel(16'h3000, 8'h00, 1, 0, "R5 release");
        rel(16'h3001, 8'h01, 1, 0, "R5 release");
        rel(16'h3003, 8'h03, 1, 0, "R5 release");
        rel(16'h3100, 8'h00, 1, 0, "R5 release");
        commit(1, "R9 empty after releasing all");
    endtask

    task automatic t_dup();
        acq(16'h4000, 8'h00, 8'h01, 1, "R2 first acquire");
        acq(16'h4000, 8'h00, 8'h01, 0, "R11 duplicate falls back");
        rel(16'h4000, 8'h00, 1, 0, "R11 single release");
        ld(16'h4000, 0, 0, "R11 no second entry left");
        rel(16'h5000, 8'h00, 0, 0, "R7 unknown release is plain");
    endtask

    task automatic t_mismatch();
        acq(16'h6000, 8'h00, 8'h01, 1, "R2 acquire A");
        acq(16'h6100, 8'h07, 8'h09, 1, "R2 acquire B");
        rel(16'h6000, 8'h05, 0, 1, "R6 wrong value aborts");
        ld(16'h6100, 0, 0, "R6 entries dropped");
        acq(16'h6200, 8'h00, 8'h01, 0, "R6 elision off after abort");
        commit(1, "R9 commit after abort");
        acq(16'h6200, 8'h00, 8'h01, 1, "R9 commit re-enables elision");
        rel(16'h6200, 8'h00, 1, 0, "R5 release");
    endtask

    task automatic t_abort();
        acq(16'h7000, 8'h00, 8'h01, 1, "R2 acquire");
        pulse_abort();
        ld(16'h7000, 0, 0, "R8 abort drops entries");
        acq(16'h7100, 8'h00, 8'h01, 0, "R8 fallback after abort");
        acq(16'h7200, 8'h00, 8'h01, 0, "R8 still fallback");
        commit(1, "R9 commit");
        acq(16'h7100, 8'h00, 8'h01, 1, "R8 elision back after commit");
        rel(16'h7100, 8'h00, 1, 0, "R5 release");
    endtask

    task automatic t_txn();
        acq(16'h8000, 8'h00, 8'h01, 1, "R2 acquire");
        pulse_txn();
        ld(16'h8000, 0, 0, "R10 new transaction drops entries");
        acq(16'h8100, 8'h00, 8'h01, 1, "R10 mode unchanged");
        pulse_txn();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        t_reset();
        t_basic();
        t_full();
        t_dup();
        t_mismatch();
        t_abort();
        t_txn();
        begin_cycle();
        @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule